// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block decides how the control endpoint of a low-speed USB device function answers the host. It takes a token that the packet front end has already decoded and matched to the device address and endpoint. From a small set of firmware-owned settings and two completion flags that hardware sets, it picks one answer: STALL, NAK, a DATA0 or DATA1 packet with its byte count, or quiet acceptance of the data that follows, ending in ACK. The front end turns that answer into bits on the wire. NRZI coding, bit stuffing, CRC, the packet buffer and address matching all sit outside this block.

Firmware writes every setting at once through one write strobe. The settings are:

- the sequence bit, which picks DATA0 or DATA1;
- the force-stall bit;
- the transmit and receive enable bits;
- a 4-bit transmit length.

It clears each completion flag with its own one-cycle strobe. Each answer appears on `resp` for exactly one cycle. It is registered, so it shows in the cycle after the input that caused it. `resp` is NONE in every other cycle.

The codes on `resp` are 0 NONE, 1 ACK, 2 NAK, 3 STALL, 4 DATA0 and 5 DATA1. The codes on `tok_type` are 0 IN, 1 OUT, 2 SETUP and 3 reserved.

Top module: `ep0_resp`

## Requirements
- R1: After reset, the sequence, stall, enable, length and both done flags read 0, and `resp` is NONE (0) with `resp_len` 0.
- R2: An IN token (code 0) that is neither stalled nor NAKed gives DATA1 (5) when `seq_o` is 1 and DATA0 (4) when it is 0, one cycle after the token. Hardware never changes `seq_o`; only a configuration write does.
- R3: With a DATA answer, `resp_len` is the programmed length clamped to 8, so 9 to 15 give 8 and 0 gives 0. With every other answer, `resp_len` is 0.
- R4: While `stall_o` is 1, an IN or OUT token gives STALL (3), whatever the enable bits and done flags hold.
- R5: A SETUP token (code 2) clears `stall_o` at the next edge. This clear wins over a configuration write in the same cycle that sets the stall bit.
- R6: When not stalled, an IN token gives NAK (2) if `tx_en_o` is 0 or `tx_done` is 1.
- R7: When not stalled, an OUT token (code 1) gives NAK (2) if `rx_en_o` is 0 or `rx_done` is 1.
- R8: After a DATA answer, a `host_ack` pulse before the next token sets `tx_done`, with `resp` staying NONE. If a new token arrives first, the wait ends and `tx_done` stays 0. A `host_ack` at any other time is ignored.
- R9: An OUT token that is accepted gives NONE. After it, an `rx_good` pulse gives ACK (1) and sets `rx_done`, while an `rx_bad` pulse gives NONE and leaves `rx_done` at 0.
- R10: A SETUP token is always accepted, even when stalled and with both enable bits at 0. It gives NONE, and the `rx_good` that follows gives ACK and sets `rx_done`.
- R11: `tx_done_clr` and `rx_done_clr` each clear their flag at the next edge. If hardware sets the same flag in that cycle, the set wins.
- R12: A token with the reserved code 3 gives NONE and leaves a pending wait intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_we | input | 1 | Loads all configuration fields at once |
| cfg_seq | input | 1 | New sequence bit |
| cfg_stall | input | 1 | New force-stall bit |
| cfg_tx_en | input | 1 | New transmit enable |
| cfg_rx_en | input | 1 | New receive enable |
| cfg_tx_len | input | 4 | New transmit length |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| tok_valid | input | 1 | A decoded token for this endpoint is present |
| tok_type | input | 2 | Token code: 0 IN, 1 OUT, 2 SETUP, 3 reserved |
| host_ack | input | 1 | Host sent ACK for our data packet |
| rx_good | input | 1 | Data packet received without error |
| rx_bad | input | 1 | Data packet received with error |
| seq_o | output | 1 | Sequence bit |
| stall_o | output | 1 | Force-stall bit |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| tx_len_o | output | 4 | Programmed transmit length |
| tx_done | output | 1 | Transmit completion flag |
| rx_done | output | 1 | Receive completion flag |
| resp | output | 3 | One-cycle answer code |
| resp_len | output | 4 | Byte count sent with a DATA answer |

## Verification
The assertions take for granted that every input pulse lasts one cycle. They also assume that the front end raises at most one of `tok_valid`, `host_ack`, `rx_good` and `rx_bad` in any cycle, since a token on the wire cannot overlap a handshake or a data packet. The stimulus tasks drive one event at a time, each on a falling edge, and lower it at the next falling edge. A configuration write or a clear strobe is combined with an event only in the two cases that exercise the R5 and R11 priority rules.

// File: rtl/ep0_resp.sv
module ep0_resp #(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_seq,
  input  logic             cfg_stall,
  input  logic             cfg_tx_en,
  input  logic             cfg_rx_en,
  input  logic [LEN_W-1:0] cfg_tx_len,
  input  logic             tx_done_clr,
  input  logic             rx_done_clr,
  input  logic             tok_valid,
  input  logic [1:0]       tok_type,
  input  logic             host_ack,
  input  logic             rx_good,
  input  logic             rx_bad,
  output logic             seq_o,
  output logic             stall_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic [LEN_W-1:0] tx_len_o,
  output logic             tx_done,
  output logic             rx_done,
  output logic [2:0]       resp,
  output logic [LEN_W-1:0] resp_len
);

  localparam logic [2:0] R_NONE  = 3'd0;
  localparam logic [2:0] R_ACK   = 3'd1;
  localparam logic [2:0] R_NAK   = 3'd2;
  localparam logic [2:0] R_STALL = 3'd3;
  localparam logic [2:0] R_DATA0 = 3'd4;
  localparam logic [2:0] R_DATA1 = 3'd5;

  localparam logic [1:0] T_IN    = 2'd0;
  localparam logic [1:0] T_OUT   = 2'd1;
  localparam logic [1:0] T_SETUP = 2'd2;

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  typedef enum logic [1:0] {S_IDLE, S_HACK, S_OUTD, S_SETD} wait_t;

  wait_t            st, st_n;
  logic [2:0]       resp_n;
  logic [LEN_W-1:0] len_n;
  logic             txd_set, rxd_set;

  wire is_in    = tok_valid && tok_type == T_IN;
  wire is_out   = tok_valid && tok_type == T_OUT;
  wire is_setup = tok_valid && tok_type == T_SETUP;
  wire any_tok  = is_in || is_out || is_setup;

  wire              in_nak  = !tx_en_o || tx_done;
  wire              out_nak = !rx_en_o || rx_done;
  wire [LEN_W-1:0]  len_cl  = (tx_len_o > LEN_CAP) ? LEN_CAP : tx_len_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_o    <= 1'b0;
      stall_o  <= 1'b0;
      tx_en_o  <= 1'b0;
      rx_en_o  <= 1'b0;
      tx_len_o <= '0;
    end else begin
      if (cfg_we) begin
        seq_o    <= cfg_seq;
        stall_o  <= cfg_stall;
        tx_en_o  <= cfg_tx_en;
        rx_en_o  <= cfg_rx_en;
        tx_len_o <= cfg_tx_len;
      end
      if (is_setup) stall_o <= 1'b0;
    end
  end

  always_comb begin
    resp_n  = R_NONE;
    len_n   = '0;
    st_n    = st;
    txd_set = 1'b0;
    rxd_set = 1'b0;
    if (any_tok) begin
      st_n = S_IDLE;
      if (is_setup) begin
        st_n = S_SETD;
      end else if (stall_o) begin
        resp_n = R_STALL;
      end else if (is_in) begin
        if (in_nak) begin
          resp_n = R_NAK;
        end else begin
          resp_n = seq_o ? R_DATA1 : R_DATA0;
          len_n  = len_cl;
          st_n   = S_HACK;
        end
      end else begin
        if (out_nak) resp_n = R_NAK;
        else         st_n   = S_OUTD;
      end
    end else begin
      case (st)
        S_HACK: if (host_ack) begin
          txd_set = 1'b1;
          st_n    = S_IDLE;
        end
        S_OUTD, S_SETD: if (rx_good) begin
          resp_n  = R_ACK;
          rxd_set = 1'b1;
          st_n    = S_IDLE;
        end else if (rx_bad) begin
          st_n = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      resp     <= R_NONE;
      resp_len <= '0;
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
    end else begin
      st       <= st_n;
      resp     <= resp_n;
      resp_len <= len_n;
      tx_done  <= txd_set || (tx_done && !tx_done_clr);
      rx_done  <= rxd_set || (rx_done && !rx_done_clr);
    end
  end

endmodule

// File: rtl/ep0_resp_chk.sv
module ep0_resp_chk #(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             tok_valid,
  input logic [1:0]       tok_type,
  input logic             host_ack,
  input logic             seq_o,
  input logic             stall_o,
  input logic             tx_en_o,
  input logic             tx_done,
  input logic [2:0]       resp,
  input logic [LEN_W-1:0] resp_len
);

  // R4
  stall_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_type < 2'd2 && stall_o) |=> resp == 3'd3);

  // R5
  setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_type == 2'd2) |=> !stall_o);

  // R6
  in_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_type == 2'd0 && !stall_o && (!tx_en_o || tx_done)) |=> resp == 3'd2);

  // R2
  in_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_type == 2'd0 && !stall_o && tx_en_o && !tx_done)
      |=> resp == ($past(seq_o) ? 3'd5 : 3'd4));

  // R2
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(seq_o));

  // R3
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_len <= LEN_W'(MAX_LEN));

  // R3
  len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp != 3'd4 && resp != 3'd5) |-> resp_len == '0);

  // R8
  txd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(host_ack));

endmodule

bind ep0_resp ep0_resp_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) i_chk (.*);

// File: tb/test_ep0_resp.sv
module test_ep0_resp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_seq = 0, cfg_stall = 0, cfg_tx_en = 0, cfg_rx_en = 0;
  logic [3:0] cfg_tx_len = 0;
  logic tx_done_clr = 0, rx_done_clr = 0;
  logic tok_valid = 0;
  logic [1:0] tok_type = 0;
  logic host_ack = 0, rx_good = 0, rx_bad = 0;
  logic seq_o, stall_o, tx_en_o, rx_en_o, tx_done, rx_done;
  logic [3:0] tx_len_o, resp_len;
  logic [2:0] resp;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_resp i_ep0_resp (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seq(cfg_seq),
    .cfg_stall(cfg_stall), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .cfg_tx_len(cfg_tx_len), .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
    .tok_valid(tok_valid), .tok_type(tok_type), .host_ack(host_ack),
    .rx_good(rx_good), .rx_bad(rx_bad), .seq_o(seq_o), .stall_o(stall_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .tx_len_o(tx_len_o),
    .tx_done(tx_done), .rx_done(rx_done), .resp(resp), .resp_len(resp_len)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg(input logic s, input logic st, input logic te, input logic re, input logic [3:0] l);
    cfg_we = 1; cfg_seq = s; cfg_stall = st; cfg_tx_en = te; cfg_rx_en = re; cfg_tx_len = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic tok(input logic [1:0] t);
    tok_valid = 1; tok_type = t;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic pulse_hack();
    host_ack = 1; @(negedge clk); host_ack = 0;
  endtask

  task automatic pulse_good();
    rx_good = 1; @(negedge clk); rx_good = 0;
  endtask

  task automatic pulse_bad();
    rx_bad = 1; @(negedge clk); rx_bad = 0;
  endtask

  task automatic clr_both();
    tx_done_clr = 1; rx_done_clr = 1; @(negedge clk);
    tx_done_clr = 0; rx_done_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 seq", seq_o, 0);
    check("R1 stall", stall_o, 0);
    check("R1 tx_en", tx_en_o, 0);
    check("R1 rx_en", rx_en_o, 0);
    check("R1 len", tx_len_o, 0);
    check("R1 tx_done", tx_done, 0);
    check("R1 rx_done", rx_done, 0);
    check("R1 resp", resp, 0);
    check("R1 resp_len", resp_len, 0);
  endtask

  task automatic t_in_data();
    cfg(0, 0, 1, 0, 4'd5);
    tok(2'd0);
    check("R2 DATA0", resp, 4);
    check("R3 len5", resp_len, 5);
    @(negedge clk);
    check("R2 one cycle", resp, 0);
    cfg(1, 0, 1, 0, 4'd5);
    tok(2'd0);
    check("R2 DATA1", resp, 5);
    check("R8 no ack keeps clear", tx_done, 0);
    tok(2'd3);
    check("R12 reserved none", resp, 0);
    pulse_hack();
    check("R12 wait kept, R8 set", tx_done, 1);
    check("R8 resp none", resp, 0);
    check("R2 seq not toggled", seq_o, 1);
    tok(2'd0);
    check("R6 NAK done", resp, 2);
    check("R3 NAK len0", resp_len, 0);
    clr_both();
    check("R11 clear tx", tx_done, 0);
    pulse_hack();
    check("R8 stray ack ignored", tx_done, 0);
  endtask

  task automatic t_len();
    cfg(0, 0, 1, 0, 4'd8);
    tok(2'd0);
    check("R3 len8", resp_len, 8);
    cfg(0, 0, 1, 0, 4'd12);
    tok(2'd0);
    check("R3 len12 clamp", resp_len, 8);
    cfg(0, 0, 1, 0, 4'd0);
    tok(2'd0);
    check("R3 len0 data", resp, 4);
    check("R3 len0", resp_len, 0);
    cfg(0, 0, 0, 0, 4'd3);
    tok(2'd0);
    check("R6 NAK disabled", resp, 2);
  endtask

  task automatic t_stall();
    cfg(0, 1, 0, 0, 4'd2);
    tok(2'd0);
    check("R4 IN stall", resp, 3);
    tok(2'd1);
    check("R4 OUT stall", resp, 3);
    cfg(0, 1, 1, 1, 4'd2);
    tok(2'd0);
    check("R4 IN stall enabled", resp, 3);
    check("R4 stall len0", resp_len, 0);
  endtask

  task automatic t_setup();
    cfg(0, 1, 0, 0, 4'd0);
    tok(2'd2);
    check("R10 setup none", resp, 0);
    check("R5 stall cleared", stall_o, 0);
    pulse_good();
    check("R10 setup ack", resp, 1);
    check("R10 rx_done", rx_done, 1);
    clr_both();
    check("R11 clear rx", rx_done, 0);
    cfg_we = 1; cfg_stall = 1; cfg_seq = 0; cfg_tx_en = 0; cfg_rx_en = 0; cfg_tx_len = 0;
    tok_valid = 1; tok_type = 2'd2;
    @(negedge clk);
    cfg_we = 0; tok_valid = 0;
    check("R5 setup beats write", stall_o, 0);
    pulse_bad();
    check("R10 bad setup none", resp, 0);
  endtask

  task automatic t_out();
    cfg(0, 0, 0, 1, 4'd0);
    tok(2'd1);
    check("R9 accept none", resp, 0);
    pulse_bad();
    check("R9 bad none", resp, 0);
    check("R9 bad no flag", rx_done, 0);
    pulse_good();
    check("R9 late good ignored", rx_done, 0);
    tok(2'd1);
    pulse_good();
    check("R9 ack", resp, 1);
    check("R9 rx_done", rx_done, 1);
    tok(2'd1);
    check("R7 NAK done", resp, 2);
    cfg(0, 0, 0, 0, 4'd0);
    clr_both();
    tok(2'd1);
    check("R7 NAK disabled", resp, 2);
  endtask

  task automatic t_set_wins();
    cfg(1, 0, 1, 0, 4'd1);
    tok(2'd0);
    host_ack = 1; tx_done_clr = 1;
    @(negedge clk);
    host_ack = 0; tx_done_clr = 0;
    check("R11 set wins", tx_done, 1);
    clr_both();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_in_data();
    t_len();
    t_stall();
    t_setup();
    t_out();
    t_set_wins();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule